// File: doc/BRIEF.md
# State-Retaining Register Bank with Isolated Outputs

This block is a bank of flops that sits inside a power domain which can be switched off. Every bit has a working flop, which loses its value when the domain loses power, and a backup flop assumed to be on an always-powered supply. A save pulse copies the working value into the backup. A restore pulse copies the backup back into the working flop once the domain is powered again. Without a restore, a domain that comes back up holds garbage until it is reset or rewritten.

The bank outputs cross into a domain that stays powered, so they pass through an isolation stage. While isolation is off, the stage acts as a plain buffer. While isolation is on, the stage drives a safe value. A build parameter picks that value: all zeros, all ones, or the value the outputs carried just before isolation was raised. A power manager is expected to work in this order: raise isolation, save, drop power. On the way back it restores power, restores the value and then releases isolation. A save or restore issued while power is absent is reported on an error output.

Top module: `retention_iso_bank`

## Requirements
- R1: While `rst_n` is low, the working flops take `RESET_VAL` and `proto_err` is 0. Reset leaves the backup copy unchanged.
- R2: With power on, restore low and `wr_en` high at a clock edge, the working value becomes `wr_data` after that edge.
- R3: With power on and `save` high at an edge, the backup takes the working value held before that edge. In every other cycle, the backup keeps its value.
- R4: With power on and `restore` high at an edge, the working value becomes the backup value, even if `wr_en` is high in the same cycle.
- R5: While `pwr_on` is low, the working value is lost and writes have no effect. After power returns, a restore brings back the last saved value.
- R6: While `iso_en` is low, `q_out` equals the working value in the same cycle, including the cycle in which isolation is released.
- R7: With `ISO_MODE` set to clamp-low, `q_out` is all zeros while `iso_en` is high. With clamp-high, it is all ones.
- R8: With `ISO_MODE` set to hold-last, `q_out` keeps the value it showed just before `iso_en` rose, even while the working value changes underneath.
- R9: `proto_err` is high for exactly the cycle after an edge at which `save` or `restore` was high while `pwr_on` was low. Otherwise it is low.
- R10: When save and restore are both high at one powered edge, the working value and the backup exchange contents.
- R11: A save issued while power is off leaves the backup unchanged. The backup also survives reset, so a restore after reset returns the last value saved while powered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the working flops |
| pwr_on | input | 1 | Power-good flag of the switchable domain |
| wr_en | input | 1 | Write strobe for the working flops |
| wr_data | input | WIDTH | Write data |
| save | input | 1 | Copy the working value into the backup |
| restore | input | 1 | Copy the backup into the working flops |
| iso_en | input | 1 | Isolation enable for the outputs |
| q_out | output | WIDTH | Isolated bank outputs |
| proto_err | output | 1 | One-cycle flag for save or restore without power |

## Verification
The hardest situation to reach is a full power cycle in which the backup must be the only source of the value. To get there, the stimulus saves a value and raises isolation. It then drops power and keeps driving writes, saves and restores while the domain is off. Finally it powers back up, restores and releases isolation.

The same sequence also runs with a reset pulse between the save and the restore, which shows that the backup is independent of reset. A long pseudo-random phase with occasional power loss then drives all three isolation variants side by side. A model that tracks which values are still defined compares every output on every clock.

// File: rtl/ret_iso_pkg.sv
`timescale 1ns/1ps
package ret_iso_pkg;

   // Output behaviour of the isolation stage while isolation is active
   typedef enum logic [1:0] {
      ISO_CLAMP_LO  = 2'd0,
      ISO_CLAMP_HI  = 2'd1,
      ISO_HOLD_LAST = 2'd2
   } iso_mode_e;

   // Qualified control strobes shared by every bit of the bank
   typedef struct packed {
      logic wr_ok;
      logic save_ok;
      logic restore_ok;
   } ret_ctrl_t;

endpackage

// File: rtl/ret_ctrl.sv
`timescale 1ns/1ps
// Qualifies the raw controls against the power flag and raises the
// protocol error for save/restore requests made without power.
module ret_ctrl
   import ret_iso_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pwr_on,
   input  logic      wr_en,
   input  logic      save,
   input  logic      restore,
   output ret_ctrl_t ctrl_o,
   output logic      err_o
);

   logic bad_req;

   always_comb begin
      ctrl_o.restore_ok = pwr_on & restore;
      ctrl_o.save_ok    = pwr_on & save;
      // restore wins over an ordinary write in the same cycle
      ctrl_o.wr_ok      = pwr_on & wr_en & ~restore;
      bad_req           = ~pwr_on & (save | restore);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_o <= 1'b0;
      end else begin
         err_o <= bad_req;
      end
   end

endmodule

// File: rtl/ret_bit_cell.sv
`timescale 1ns/1ps
// One retained bit: working flop, always-on backup flop and the
// isolation variant chosen by MODE.
module ret_bit_cell
   import ret_iso_pkg::*;
#(
   parameter iso_mode_e MODE    = ISO_HOLD_LAST,
   parameter logic      RST_BIT = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pwr_on,
   input  ret_ctrl_t ctrl,
   input  logic      wr_bit,
   input  logic      iso_en,
   output logic      main_o,
   output logic      shadow_o,
   output logic      q_o
);

   logic main_r;
   logic main_nxt;
   logic shadow_r;

   always_comb begin
      if (!pwr_on) begin
         main_nxt = 1'bx;            // content is lost without supply
      end else if (ctrl.restore_ok) begin
         main_nxt = shadow_r;
      end else if (ctrl.wr_ok) begin
         main_nxt = wr_bit;
      end else begin
         main_nxt = main_r;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_r <= RST_BIT;
      end else begin
         main_r <= main_nxt;
      end
   end

   // backup copy lives on the always-on supply: no reset
   always_ff @(posedge clk) begin
      if (ctrl.save_ok) begin
         shadow_r <= main_r;
      end
   end

   assign main_o   = main_r;
   assign shadow_o = shadow_r;

   generate
      case (MODE)
         ISO_CLAMP_LO: begin : g_clamp_lo
            assign q_o = iso_en ? 1'b0 : main_r;
         end
         ISO_CLAMP_HI: begin : g_clamp_hi
            assign q_o = iso_en ? 1'b1 : main_r;
         end
         ISO_HOLD_LAST: begin : g_hold
            logic hold_r;
            // tracks the value the output shows after every edge at
            // which isolation was off, so raising isolation is seamless
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  hold_r <= RST_BIT;
               end else if (!iso_en) begin
                  hold_r <= main_nxt;
               end
            end
            assign q_o = iso_en ? hold_r : main_r;
         end
         default: begin : g_bad_mode
            $error("ret_bit_cell: unsupported isolation mode");
         end
      endcase
   endgenerate

endmodule

// File: rtl/retention_iso_bank.sv
`timescale 1ns/1ps
module retention_iso_bank
   import ret_iso_pkg::*;
#(
   parameter int unsigned       WIDTH     = 16,
   parameter iso_mode_e         ISO_MODE  = ISO_HOLD_LAST,
   parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_on,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             save,
   input  logic             restore,
   input  logic             iso_en,
   output logic [WIDTH-1:0] q_out,
   output logic             proto_err
);

   localparam int unsigned MAX_WIDTH = 1024;

   generate
      if (WIDTH < 1) begin : g_chk_min
         $error("retention_iso_bank: WIDTH must be at least 1");
      end
      if (WIDTH > MAX_WIDTH) begin : g_chk_max
         $error("retention_iso_bank: WIDTH exceeds supported maximum");
      end
   endgenerate

   ret_ctrl_t        ctrl;
   logic [WIDTH-1:0] main_q;
   logic [WIDTH-1:0] shadow_q;

   ret_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_on  (pwr_on),
      .wr_en   (wr_en),
      .save    (save),
      .restore (restore),
      .ctrl_o  (ctrl),
      .err_o   (proto_err)
   );

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         ret_bit_cell #(
            .MODE    (ISO_MODE),
            .RST_BIT (RESET_VAL[i])
         ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .pwr_on   (pwr_on),
            .ctrl     (ctrl),
            .wr_bit   (wr_data[i]),
            .iso_en   (iso_en),
            .main_o   (main_q[i]),
            .shadow_o (shadow_q[i]),
            .q_o      (q_out[i])
         );
      end
   endgenerate

endmodule

// File: rtl/ret_iso_checker.sv
`timescale 1ns/1ps
module ret_iso_checker
   import ret_iso_pkg::*;
#(
   parameter int unsigned WIDTH    = 16,
   parameter iso_mode_e   ISO_MODE = ISO_HOLD_LAST
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_on,
   input logic             wr_en,
   input logic [WIDTH-1:0] wr_data,
   input logic             save,
   input logic             restore,
   input logic             iso_en,
   input logic [WIDTH-1:0] main_q,
   input logic [WIDTH-1:0] shadow_q,
   input logic [WIDTH-1:0] q_out,
   input logic             proto_err
);

   assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on && wr_en && !restore) |=> (main_q == $past(wr_data)));

   assert_save_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on && save) |=> (shadow_q == $past(main_q)));

   assert_shadow_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwr_on && save) |=> $stable(shadow_q));

   assert_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on && restore) |=> (main_q == $past(shadow_q)));

   assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !iso_en |-> (q_out == main_q));

   assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_on && (save || restore)) |=> proto_err);

   assert_err_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!pwr_on && (save || restore)) |=> !proto_err);

   generate
      if (ISO_MODE == ISO_CLAMP_LO) begin : g_a_lo
         assert_clamp_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
            iso_en |-> (q_out == '0));
      end else if (ISO_MODE == ISO_CLAMP_HI) begin : g_a_hi
         assert_clamp_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
            iso_en |-> (q_out == '1));
      end else begin : g_a_hold
         assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (iso_en && $past(iso_en)) |-> $stable(q_out));
      end
   endgenerate

endmodule

bind retention_iso_bank ret_iso_checker #(
   .WIDTH    (WIDTH),
   .ISO_MODE (ISO_MODE)
) u_chk (.*);

// File: tb/tb_retention_iso_bank.sv
`timescale 1ns/1ps
module tb_retention_iso_bank;
   import ret_iso_pkg::*;

   localparam int W = 8;
   localparam logic [W-1:0] RV = 8'hA5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_i = 1'b1, wr_i = 1'b0, sv_i = 1'b0, rs_i = 1'b0, iso_i = 1'b0;
   logic [W-1:0] d_i = '0;
   logic [W-1:0] q_hold, q_lo, q_hi;
   logic e_hold, e_lo, e_hi;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   retention_iso_bank #(.WIDTH(W), .ISO_MODE(ISO_HOLD_LAST), .RESET_VAL(RV)) dut (
      .clk(clk), .rst_n(rst_n), .pwr_on(pwr_i), .wr_en(wr_i), .wr_data(d_i),
      .save(sv_i), .restore(rs_i), .iso_en(iso_i), .q_out(q_hold), .proto_err(e_hold));
   retention_iso_bank #(.WIDTH(W), .ISO_MODE(ISO_CLAMP_LO), .RESET_VAL(RV)) dut_lo (
      .clk(clk), .rst_n(rst_n), .pwr_on(pwr_i), .wr_en(wr_i), .wr_data(d_i),
      .save(sv_i), .restore(rs_i), .iso_en(iso_i), .q_out(q_lo), .proto_err(e_lo));
   retention_iso_bank #(.WIDTH(W), .ISO_MODE(ISO_CLAMP_HI), .RESET_VAL(RV)) dut_hi (
      .clk(clk), .rst_n(rst_n), .pwr_on(pwr_i), .wr_en(wr_i), .wr_data(d_i),
      .save(sv_i), .restore(rs_i), .iso_en(iso_i), .q_out(q_hi), .proto_err(e_hi));

   // behavioural reference: values plus a flag saying whether they are defined
   logic [W-1:0] m_main, m_shadow, m_hold;
   bit m_mk = 1'b0, m_sk = 1'b0, m_hk = 1'b0, m_err = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_main = RV; m_mk = 1'b1; m_hold = RV; m_hk = 1'b1; m_err = 1'b0;
      end else begin
         logic [W-1:0] nm;
         bit nk;
         if (!pwr_i) begin
            nm = '0; nk = 1'b0;
         end else if (rs_i) begin
            nm = m_shadow; nk = m_sk;
         end else if (wr_i) begin
            nm = d_i; nk = 1'b1;
         end else begin
            nm = m_main; nk = m_mk;
         end
         if (pwr_i && sv_i) begin
            m_shadow = m_main; m_sk = m_mk;
         end
         m_err = !pwr_i && (sv_i || rs_i);
         if (!iso_i) begin
            m_hold = nm; m_hk = nk;
         end
         m_main = nm; m_mk = nk;
      end
   end

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cmp_all();
      if (!iso_i) begin
         if (m_mk) begin
            chk("R6 transparent hold-variant", q_hold, m_main);
            chk("R6 transparent clamp-low", q_lo, m_main);
            chk("R6 transparent clamp-high", q_hi, m_main);
         end
      end else begin
         chk("R7 clamp-low", q_lo, '0);
         chk("R7 clamp-high", q_hi, '1);
         if (m_hk) chk("R8 hold-last", q_hold, m_hold);
      end
      chk("R9 err hold-variant", {7'd0, e_hold}, {7'd0, m_err});
      chk("R9 err clamp-low", {7'd0, e_lo}, {7'd0, m_err});
      chk("R9 err clamp-high", {7'd0, e_hi}, {7'd0, m_err});
   endtask

   task automatic cyc(input logic w, input logic [W-1:0] d, input logic s,
                      input logic r, input logic p, input logic i);
      @(negedge clk);
      wr_i = w; d_i = d; sv_i = s; rs_i = r; pwr_i = p; iso_i = i;
      #2 cmp_all();
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      repeat (3) @(negedge clk);
      #2;
      chk("R1 reset value", q_hold, RV);
      chk("R1 reset value clamp-low", q_lo, RV);
      chk("R1 reset err", {7'd0, e_hold}, 8'd0);
      @(negedge clk); rst_n = 1'b1;

      // write then read
      cyc(1, 8'h3C, 0, 0, 1, 0);
      cyc(0, 8'h00, 0, 0, 1, 0);
      chk("R2 write", q_hold, 8'h3C);
      // save, overwrite, then restore competing with a write
      cyc(0, 8'h00, 1, 0, 1, 0);
      cyc(1, 8'h77, 0, 0, 1, 0);
      cyc(0, 8'h00, 0, 0, 1, 0);
      chk("R2 second write", q_hold, 8'h77);
      cyc(1, 8'h11, 0, 1, 1, 0);
      cyc(0, 8'h00, 0, 0, 1, 0);
      chk("R4 restore beats write / R3 saved", q_hold, 8'h3C);
      // simultaneous save and restore swap contents
      cyc(1, 8'h5A, 0, 0, 1, 0);
      cyc(0, 8'h00, 1, 1, 1, 0);
      cyc(0, 8'h00, 0, 0, 1, 0);
      chk("R10 swap main", q_hold, 8'h3C);
      cyc(0, 8'h00, 0, 1, 1, 0);
      cyc(0, 8'h00, 0, 0, 1, 0);
      chk("R10 swap shadow", q_hold, 8'h5A);
      // isolation variants
      cyc(1, 8'h96, 0, 0, 1, 0);
      cyc(0, 8'h00, 0, 0, 1, 1);
      chk("R8 hold on raise", q_hold, 8'h96);
      chk("R7 clamp-low", q_lo, 8'h00);
      chk("R7 clamp-high", q_hi, 8'hFF);
      cyc(1, 8'h21, 0, 0, 1, 1);
      cyc(0, 8'h00, 0, 0, 1, 1);
      chk("R8 hold under write", q_hold, 8'h96);
      cyc(0, 8'h00, 0, 0, 1, 0);
      chk("R6 release hold-variant", q_hold, 8'h21);
      chk("R6 release clamp-high", q_hi, 8'h21);
      // full power cycle with illegal requests while off
      cyc(0, 8'h00, 1, 0, 1, 0);
      cyc(0, 8'h00, 0, 0, 1, 1);
      cyc(0, 8'h00, 0, 0, 0, 1);
      cyc(1, 8'h0F, 0, 0, 0, 1);
      cyc(0, 8'h00, 1, 0, 0, 1);
      cyc(0, 8'h00, 0, 0, 0, 1);
      chk("R9 err after save off", {7'd0, e_hold}, 8'd1);
      cyc(0, 8'h00, 0, 1, 0, 1);
      cyc(0, 8'h00, 0, 0, 0, 1);
      chk("R9 err after restore off", {7'd0, e_lo}, 8'd1);
      cyc(0, 8'h00, 0, 0, 1, 1);
      chk("R9 err single cycle", {7'd0, e_hi}, 8'd0);
      cyc(0, 8'h00, 0, 1, 1, 1);
      cyc(0, 8'h00, 0, 0, 1, 0);
      chk("R5 restore after power loss", q_hold, 8'h21);
      chk("R11 save while off ignored", q_lo, 8'h21);
      // backup survives reset
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); #2;
      chk("R1 reset again", q_hold, RV);
      rst_n = 1'b1;
      cyc(0, 8'h00, 0, 1, 1, 0);
      cyc(0, 8'h00, 0, 0, 1, 0);
      chk("R11 shadow across reset", q_hold, 8'h21);

      // pseudo-random phase, every output compared against the model
      lf = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
         logic p;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         p = (lf[3:0] != 4'h0);
         cyc(lf[4], lf[15:8], lf[5] & lf[6], lf[7] & lf[2], p, lf[1] | ~p);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule